// File: doc/BRIEF.md
# Two-Channel Pattern LED Blinker

This block drives a green and a red indicator LED from a small word-wide register interface. Each LED channel owns a 32-bit pattern word, where a 1 bit means lit, and a delay word holding a negative count that sets how many clocks each pattern bit is shown. A shared control word picks, per channel, one of four behaviours: forced dark, forced lit, a static copy of pattern bit 0, or a repeating walk through the pattern from its top bit down to bit 0. When both LEDs are lit the viewer sees a mixed colour; the block itself has no colour logic.

Software programs the pattern and the delay while the walk is stopped, then sets both walk-enable bits of the channel. The walk starts at bit 31 on the first cycle after the enabling write and moves one bit lower every N clocks for a delay of -N, wrapping from bit 0 back to bit 31. Clearing either walk-enable bit parks the channel at bit 31 again, so every new start is repeatable.

Top module: `led_blink_top`

## Requirements
- R1: After reset every register reads 0 and both LED outputs are 0.
- R2: Writes land at address 0 (control), 1 (green pattern), 2 (green delay), 3 (red pattern), 4 (red delay) and read back unchanged on `regRdData` in the same cycle the address is presented; addresses 5 to 7 read 0 and writes to them change no register.
- R3: Control bit 2 forces the green LED to 0 and control bit 3 forces the red LED to 0, over every other control bit.
- R4: With its force-off bit clear, control bit 4 forces green to 1 and control bit 5 forces red to 1.
- R5: With no force bit set, control bit 0 (green) or bit 9 (red) makes the LED follow pattern bit 0 while the channel is not walking; with the pattern-enable bit clear and no force bit, the LED is 0.
- R6: The green walk runs only while control bits 1 and 6 are both set, the red walk only while bits 10 and 12 are both set; either bit alone leaves the static bit-0 behaviour.
- R7: While walking with pattern output enabled and a delay of -N (N at least 1), the LED shows pattern bit 31 for the N cycles following the enabling write, then each lower bit for N cycles.
- R8: After bit 0 has been shown for N cycles the walk wraps to bit 31.
- R9: Stopping a walk and starting it again restarts at bit 31 with a full N-cycle dwell.
- R10: The two channels step independently, each at the rate set by its own delay word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| ledGreen | output | 1 | Green LED drive, 1 = lit |
| ledRed | output | 1 | Red LED drive, 1 = lit |

## Verification
A wrong bit index or a step counter that reloads one cycle early or late shows at the LED pin within one dwell period, since the pattern words chosen put differing values in neighbouring bits and each sample is compared with the bit the delay arithmetic predicts for that exact cycle. A walk that fails to wrap or restart at bit 31 shows on the first cycle after bit 0 or after re-enabling, so the sweeps run each channel through more than a full period and through a stop and restart. Force and enable priority errors appear immediately after the control write, and all sixteen combinations of the force, enable and pattern-bit-0 inputs are visited on both channels.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_GREEN = 0;
  localparam int CH_RED = 1;

  // Register word addresses; channel c uses 1+2c (pattern) and 2+2c (delay).
  localparam int ADDR_CTRL = 0;
  localparam int NUM_REGS = 1 + 2 * NUM_CH;

  // Control word bit positions, software visible.
  localparam int G_PAT_EN = 0;
  localparam int G_WALK_A = 1;
  localparam int G_OFF = 2;
  localparam int R_OFF = 3;
  localparam int G_ON = 4;
  localparam int R_ON = 5;
  localparam int G_WALK_B = 6;
  localparam int R_PAT_EN = 9;
  localparam int R_WALK_A = 10;
  localparam int R_WALK_B = 12;

  typedef struct packed {
    logic patEn;
    logic walkRun;
    logic forceOn;
    logic forceOff;
  } chanStrobes_t;

  function automatic chanStrobes_t decodeCtrl(input logic [31:0] ctrl, input int ch);
    chanStrobes_t s;
    if (ch == CH_GREEN) begin
      s.patEn = ctrl[G_PAT_EN];
      s.walkRun = ctrl[G_WALK_A] & ctrl[G_WALK_B];
      s.forceOn = ctrl[G_ON];
      s.forceOff = ctrl[G_OFF];
    end else begin
      s.patEn = ctrl[R_PAT_EN];
      s.walkRun = ctrl[R_WALK_A] & ctrl[R_WALK_B];
      s.forceOn = ctrl[R_ON];
      s.forceOff = ctrl[R_OFF];
    end
    return s;
  endfunction

endpackage

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output chanStrobes_t      chanStrb [NUM_CH],
  output logic [DATA_W-1:0] chanPat  [NUM_CH],
  output logic [DATA_W-1:0] chanDly  [NUM_CH]
);

  logic [DATA_W-1:0] ctrlReg;
  logic [31:0] ctrlWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWrEn && regAddr == ADDR_W'(ADDR_CTRL)) ctrlReg <= regWrData;
  end

  always_comb begin
    ctrlWide = '0;
    ctrlWide[DATA_W-1:0] = ctrlReg;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] PAT_ADDR = ADDR_W'(1 + 2 * ch);
    localparam logic [ADDR_W-1:0] DLY_ADDR = ADDR_W'(2 + 2 * ch);
    logic [DATA_W-1:0] patReg, dlyReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        patReg <= '0;
        dlyReg <= '0;
      end else if (regWrEn) begin
        if (regAddr == PAT_ADDR) patReg <= regWrData;
        if (regAddr == DLY_ADDR) dlyReg <= regWrData;
      end
    end

    assign chanPat[ch] = patReg;
    assign chanDly[ch] = dlyReg;
    assign chanStrb[ch] = decodeCtrl(ctrlWide, ch);

    // R2
    pat_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == PAT_ADDR) |=> chanPat[ch] == $past(regWrData));
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) regRdData = ctrlReg;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (regAddr == ADDR_W'(1 + 2 * ch)) regRdData = chanPat[ch];
      if (regAddr == ADDR_W'(2 + 2 * ch)) regRdData = chanDly[ch];
    end
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADDR_CTRL)) |=> ctrlReg == $past(regWrData));

  // R2
  spare_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(NUM_REGS)) |-> regRdData == '0);

endmodule

// File: rtl/led_blink_channel.sv
module led_blink_channel
  import led_blink_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int DELAY_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  chanStrobes_t       strb,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [DELAY_W-1:0] delay,
  output logic               led
);

  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(PAT_W - 1);

  logic [DELAY_W-1:0] stepCnt;
  logic [IDX_W-1:0] bitIdx;
  logic lastTick;
  logic patBit;

  assign lastTick = (stepCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      bitIdx <= TOP_IDX;
    end else if (!strb.walkRun) begin
      stepCnt <= delay;
      bitIdx <= TOP_IDX;
    end else if (lastTick) begin
      stepCnt <= delay;
      bitIdx <= (bitIdx == '0) ? TOP_IDX : bitIdx - 1'b1;
    end else begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign patBit = strb.walkRun ? pattern[bitIdx] : pattern[0];

  always_comb begin
    if (strb.forceOff) led = 1'b0;
    else if (strb.forceOn) led = 1'b1;
    else if (strb.patEn) led = patBit;
    else led = 1'b0;
  end

  // R3
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOff |-> !led);

  // R9
  park_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.walkRun |=> bitIdx == TOP_IDX);

  // R7
  dwell_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.walkRun && !lastTick) |=> $stable(bitIdx));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.walkRun && lastTick && bitIdx == '0) |=> bitIdx == TOP_IDX);

endmodule

// File: rtl/led_blink_datapath.sv
module led_blink_datapath
  import led_blink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobes_t      chanStrb [NUM_CH],
  input  logic [DATA_W-1:0] chanPat  [NUM_CH],
  input  logic [DATA_W-1:0] chanDly  [NUM_CH],
  output logic [NUM_CH-1:0] leds
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    led_blink_channel #(
      .PAT_W(DATA_W),
      .DELAY_W(DATA_W)
    ) u_chan (
      .clk(clk),
      .rstN(rstN),
      .strb(chanStrb[ch]),
      .pattern(chanPat[ch]),
      .delay(chanDly[ch]),
      .led(leds[ch])
    );
  end

endmodule

// File: rtl/led_blink_top.sv
module led_blink_top
  import led_blink_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              ledGreen,
  output logic              ledRed
);

  chanStrobes_t chanStrb [NUM_CH];
  logic [DATA_W-1:0] chanPat [NUM_CH];
  logic [DATA_W-1:0] chanDly [NUM_CH];
  logic [NUM_CH-1:0] leds;

  led_blink_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .chanStrb(chanStrb),
    .chanPat(chanPat),
    .chanDly(chanDly)
  );

  led_blink_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .chanStrb(chanStrb),
    .chanPat(chanPat),
    .chanDly(chanDly),
    .leds(leds)
  );

  assign ledGreen = leds[CH_GREEN];
  assign ledRed = leds[CH_RED];

  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!ledGreen && !ledRed));

endmodule

// File: tb/tb_led_blink_top.sv
module tb_led_blink_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic ledGreen, ledRed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  led_blink_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .ledGreen(ledGreen), .ledRed(ledRed)
  );

  localparam logic [31:0] GPAT = 32'hA5C3_0F96;
  localparam logic [31:0] RPAT = 32'h3C5A_E718;
  localparam int GN = 3;
  localparam int RN = 5;
  localparam logic [31:0] WALK_ALL = 32'h0000_1643; // bits 0,1,6,9,10,12

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    check(regRdData, exp, tag);
  endtask

  function automatic logic walkBit(input logic [31:0] p, input int t, input int n);
    return p[31 - ((t / n) % 32)];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({31'b0, ledGreen}, 32'd0, "R1 green after reset");
    check({31'b0, ledRed}, 32'd0, "R1 red after reset");
    for (int a = 0; a < 5; a++) rd(3'(a), 32'd0, "R1 register after reset");

    // R2 write/readback and spare addresses
    for (int a = 0; a < 5; a++) wr(3'(a), 32'h1111_0000 * (a + 1) + 32'(a) + 32'h0000_8000);
    for (int a = 5; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h1111_0000 * (a + 1) + 32'(a) + 32'h0000_8000, "R2 readback");
    for (int a = 5; a < 8; a++) rd(3'(a), 32'd0, "R2 spare address reads 0");

    // R3 R4 R5 sweep over force-off, force-on, pattern enable and pattern bit 0
    for (int v = 0; v < 16; v++) begin
      logic pe, fo, fn, pb, exp;
      pe = v[0]; fo = v[1]; fn = v[2]; pb = v[3];
      wr(3'd0, 32'd0);
      wr(3'd1, {31'h2AAA_AAAA, pb});
      wr(3'd3, {31'h5555_5555, pb});
      wr(3'd0, (32'(pe) << 0) | (32'(fo) << 2) | (32'(fn) << 4) |
               (32'(pe) << 9) | (32'(fo) << 3) | (32'(fn) << 5));
      exp = fo ? 1'b0 : (fn ? 1'b1 : (pe & pb));
      if (fo) begin
        check({31'b0, ledGreen}, {31'b0, exp}, "R3 green force off");
        check({31'b0, ledRed}, {31'b0, exp}, "R3 red force off");
      end else if (fn) begin
        check({31'b0, ledGreen}, {31'b0, exp}, "R4 green force on");
        check({31'b0, ledRed}, {31'b0, exp}, "R4 red force on");
      end else begin
        check({31'b0, ledGreen}, {31'b0, exp}, "R5 green static bit 0");
        check({31'b0, ledRed}, {31'b0, exp}, "R5 red static bit 0");
      end
    end

    // Program walk patterns and delays with walk stopped
    wr(3'd0, 32'd0);
    wr(3'd1, GPAT);
    wr(3'd2, -32'(GN));
    wr(3'd3, RPAT);
    wr(3'd4, -32'(RN));

    // R6 one walk bit alone keeps static output
    wr(3'd0, 32'h0000_0603); // bits 0,1,9,10
    for (int t = 0; t < 40; t++) begin
      check({31'b0, ledGreen}, {31'b0, GPAT[0]}, "R6 green bit 1 alone");
      check({31'b0, ledRed}, {31'b0, RPAT[0]}, "R6 red bit 10 alone");
      @(negedge clk);
    end
    wr(3'd0, 32'h0000_1241); // bits 0,6,9,12
    for (int t = 0; t < 40; t++) begin
      check({31'b0, ledGreen}, {31'b0, GPAT[0]}, "R6 green bit 6 alone");
      check({31'b0, ledRed}, {31'b0, RPAT[0]}, "R6 red bit 12 alone");
      @(negedge clk);
    end
    wr(3'd0, 32'h0000_0201);

    // R7 R8 R10 walk both channels, green wraps at cycle 96
    wr(3'd0, WALK_ALL);
    for (int t = 0; t < 200; t++) begin
      check({31'b0, ledGreen}, {31'b0, walkBit(GPAT, t, GN)},
            (t < 32 * GN) ? "R7 green walk" : "R8 green wrap");
      check({31'b0, ledRed}, {31'b0, walkBit(RPAT, t, RN)}, "R10 red walk own rate");
      @(negedge clk);
    end

    // R9 stop, hold static, restart at bit 31
    wr(3'd0, 32'h0000_0603);
    for (int t = 0; t < 4; t++) begin
      check({31'b0, ledGreen}, {31'b0, GPAT[0]}, "R9 green stopped");
      check({31'b0, ledRed}, {31'b0, RPAT[0]}, "R9 red stopped");
      @(negedge clk);
    end
    wr(3'd0, WALK_ALL);
    for (int t = 0; t < 20; t++) begin
      check({31'b0, ledGreen}, {31'b0, walkBit(GPAT, t, GN)}, "R9 green restart");
      check({31'b0, ledRed}, {31'b0, walkBit(RPAT, t, RN)}, "R9 red restart");
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule